// File: doc/BRIEF.md
# Synchronous Exception Entry Unit

This block applies the register side effects that a 32-bit processor core needs when it takes a synchronous exception. The pipeline hands it one request. The request carries the address of the faulting instruction, the machine state word in force at that moment, a cause code with a sub-reason, a store flag and the faulting effective address. On the next clock edge the unit presents four results: the saved return address, the saved state word, the new machine state word and the redirect target. It also pulses a one-cycle redirect strobe. Causes that report a data fault also load the data fault status and the data fault address.

The request side is a valid/ready stream. `req_ready` is low during reset and high on every cycle after it, so the unit never applies back-pressure. A request is taken on each edge where `req_valid` and `req_ready` are both high, and back-to-back requests are accepted on consecutive cycles. The upstream stage must keep its fields steady only while `req_valid` is high in the cycle of acceptance. The outputs are plain registers and hold their values until the next accepted request changes them.

Cause codes (4 bits): 0 machine check, 1 data storage fault, 2 instruction storage fault, 3 alignment, 4 program, 5 floating-point unavailable, 6 system call, 7 floating-point assist. Codes 8 to 15 are not recognised. Bit positions below count from the least significant bit (bit 0).

Top module: `exc_entry_unit`

## Requirements
- R1: `req_ready` is 0 in reset and 1 from the first cycle after reset. An accepted request with a recognised cause and sub-reason raises `redirect_vld_o` for exactly the following cycle. Consecutive accepted requests give consecutive pulses.
- R2: `redirect_pc_o` is the vector base plus the vector offset. The offsets are 0x200 machine check, 0x300 data storage, 0x400 instruction storage, 0x600 alignment, 0x700 program, 0x800 FP unavailable, 0xC00 system call and 0xE00 FP assist. The base is 0xFFF00000 when bit 6 (vector prefix) of the new state word is 1, and 0 otherwise.
- R3: The new state word is the old word with bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 cleared (mask 0x0004EF32). With default parameters all other bits are kept.
- R4: SRR1 is the old state word ANDed with 0x07C0FFFF, ORed with the cause's reason bits.
- R5: SRR0 is the request address. For a system call it is the request address plus 4, wrapping modulo 2^32.
- R6: A data storage fault loads DAR with the effective address and DSISR with one reason bit. The reason bits by sub-reason are: 0 direct-store error bit 31, 1 page/translation miss bit 30, 2 protection bit 27, 3 segment miss bit 21, 4 external-access violation bit 26, 5 external-access disabled bit 20. Bit 25 is also set when `req_store` is 1.
- R7: An instruction storage fault ORs its reason into SRR1 and leaves DSISR and DAR unchanged. The reasons by sub-reason are: 0 page miss bit 30, 1 direct-store error bit 28, 2 protection bit 27, 3 segment miss bit 21.
- R8: A program exception ORs one SRR1 bit. The bits by sub-reason are: 0 FP enabled bit 20, 1 illegal bit 19, 2 privileged bit 18, 3 trap bit 17. Sub-reason 4 (unsupported optional instruction) reports as illegal, bit 19.
- R9: An alignment exception loads DAR with the effective address and DSISR with 0.
- R10: `err_unrec_o` pulses together with the redirect strobe when bit 1 (recoverable) of the old state word was 0.
- R11: An unrecognised cause code (8–15), or an unrecognised sub-reason (data storage 6–7, instruction storage 4–7, program 5–7), pulses `err_cause_o` for one cycle. No redirect strobe is given and all outputs other than the error flags keep their values.
- R12: After reset every output register is 0.
- R13: Machine check, FP unavailable, system call and FP assist leave DSISR and DAR unchanged and set no SRR1 reason bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Unit accepts a request this cycle |
| req_cia | input | 32 | Address of the excepting instruction |
| req_msr | input | 32 | Machine state word at the exception |
| req_cause | input | 4 | Cause code |
| req_sub | input | 3 | Sub-reason within the cause |
| req_store | input | 1 | Faulting access was a store |
| req_ea | input | 32 | Faulting effective address |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved state word with reason bits |
| msr_o | output | 32 | New machine state word |
| dsisr_o | output | 32 | Data fault status |
| dar_o | output | 32 | Data fault address |
| redirect_pc_o | output | 32 | Fetch redirect target |
| redirect_vld_o | output | 1 | One-cycle redirect strobe |
| err_unrec_o | output | 1 | Exception taken while not recoverable |
| err_cause_o | output | 1 | Unrecognised cause or sub-reason |

## Verification
The assertions assume that `req_valid` is low while `rst` is high and in the first cycle after reset. They also assume the request fields are settled before the clock edge on which they are taken. The bench drives every request on the falling edge and clears `req_valid` before releasing reset, so both conditions hold. The assertions also assume the per-cause state masks clear nothing in the vector prefix region that matters to alignment. The bench keeps the default masks.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int SW     = 32;
  localparam int CAUSE_W = 4;
  localparam int SUB_W   = 3;
  localparam int N_CAUSE = 8;

  // state word bit positions (LSB = 0)
  localparam int B_RI   = 1;
  localparam int B_DR   = 4;
  localparam int B_IR   = 5;
  localparam int B_IP   = 6;
  localparam int B_FE1  = 8;
  localparam int B_BE   = 9;
  localparam int B_SE   = 10;
  localparam int B_FE0  = 11;
  localparam int B_FP   = 13;
  localparam int B_PR   = 14;
  localparam int B_EE   = 15;
  localparam int B_POW  = 18;

  localparam logic [SW-1:0] ENTRY_CLEAR =
      (32'h1 << B_RI)  | (32'h1 << B_DR)  | (32'h1 << B_IR)  |
      (32'h1 << B_FE1) | (32'h1 << B_BE)  | (32'h1 << B_SE)  |
      (32'h1 << B_FE0) | (32'h1 << B_FP)  | (32'h1 << B_PR)  |
      (32'h1 << B_EE)  | (32'h1 << B_POW);

  localparam logic [SW-1:0] SAVE_KEEP = 32'h07C0_FFFF;

  typedef enum logic [CAUSE_W-1:0] {
    C_MCHK  = 4'd0,
    C_DSTOR = 4'd1,
    C_ISTOR = 4'd2,
    C_ALIGN = 4'd3,
    C_PROG  = 4'd4,
    C_FPUN  = 4'd5,
    C_SCALL = 4'd6,
    C_FPAS  = 4'd7
  } cause_e;

  typedef struct packed {
    logic          legal;
    logic          load_fault; // DSISR and DAR written
    logic [SW-1:0] save_or;    // reason bits into SRR1
    logic [SW-1:0] fault_stat; // DSISR value
  } reason_t;

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int            AW      = 32,
  parameter logic [AW-1:0] BASE_HI = 32'hFFF0_0000
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic               prefix,
  output logic [AW-1:0]      target
);
  localparam int OFS_W = 12;

  logic [OFS_W-1:0] ofs;
  logic [AW-1:0]    base;

  always_comb begin
    unique case (cause)
      C_MCHK:  ofs = 12'h200;
      C_DSTOR: ofs = 12'h300;
      C_ISTOR: ofs = 12'h400;
      C_ALIGN: ofs = 12'h600;
      C_PROG:  ofs = 12'h700;
      C_FPUN:  ofs = 12'h800;
      C_SCALL: ofs = 12'hC00;
      C_FPAS:  ofs = 12'hE00;
      default: ofs = '0;
    endcase
  end

  assign base   = prefix ? BASE_HI : '0;
  assign target = base + AW'(ofs);

endmodule

// File: rtl/exc_reason_dec.sv
module exc_reason_dec
  import exc_entry_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  input  logic [SUB_W-1:0]   sub,
  input  logic               is_store,
  output reason_t            rsn
);
  localparam logic [SW-1:0] DIR_STORE = 32'h0200_0000;

  logic [SW-1:0] dstat;
  logic          dstat_ok;
  logic [SW-1:0] istat;
  logic          istat_ok;
  logic [SW-1:0] pstat;
  logic          pstat_ok;

  // data storage reasons
  always_comb begin
    dstat_ok = 1'b1;
    unique case (sub)
      3'd0:    dstat = 32'h8000_0000;
      3'd1:    dstat = 32'h4000_0000;
      3'd2:    dstat = 32'h0800_0000;
      3'd3:    dstat = 32'h0020_0000;
      3'd4:    dstat = 32'h0400_0000;
      3'd5:    dstat = 32'h0010_0000;
      default: begin dstat = '0; dstat_ok = 1'b0; end
    endcase
  end

  // instruction storage reasons
  always_comb begin
    istat_ok = 1'b1;
    unique case (sub)
      3'd0:    istat = 32'h4000_0000;
      3'd1:    istat = 32'h1000_0000;
      3'd2:    istat = 32'h0800_0000;
      3'd3:    istat = 32'h0020_0000;
      default: begin istat = '0; istat_ok = 1'b0; end
    endcase
  end

  // program reasons; optional instruction folds into illegal
  always_comb begin
    pstat_ok = 1'b1;
    unique case (sub)
      3'd0:      pstat = 32'h0010_0000;
      3'd1, 3'd4: pstat = 32'h0008_0000;
      3'd2:      pstat = 32'h0004_0000;
      3'd3:      pstat = 32'h0002_0000;
      default:   begin pstat = '0; pstat_ok = 1'b0; end
    endcase
  end

  always_comb begin
    rsn = '0;
    unique case (cause)
      C_MCHK, C_FPUN, C_SCALL, C_FPAS: rsn.legal = 1'b1;
      C_DSTOR: begin
        rsn.legal      = dstat_ok;
        rsn.load_fault = 1'b1;
        rsn.fault_stat = dstat | (is_store ? DIR_STORE : '0);
      end
      C_ISTOR: begin
        rsn.legal   = istat_ok;
        rsn.save_or = istat;
      end
      C_ALIGN: begin
        rsn.legal      = 1'b1;
        rsn.load_fault = 1'b1;
      end
      C_PROG: begin
        rsn.legal   = pstat_ok;
        rsn.save_or = pstat;
      end
      default: rsn.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter logic [SW-1:0]              FORCE_SET = '0,
  parameter logic [N_CAUSE-1:0][SW-1:0] CAUSE_CLR = '0,
  parameter logic [N_CAUSE-1:0][SW-1:0] CAUSE_SET = '0,
  parameter logic [N_CAUSE-1:0][SW-1:0] SAVE_CLR  = '0
) (
  input  logic [SW-1:0]      old_msr,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [SW-1:0]      save_or,
  output logic [SW-1:0]      new_msr,
  output logic [SW-1:0]      save_word
);
  localparam int IDX_W = $clog2(N_CAUSE);

  logic [IDX_W-1:0] idx;
  logic [SW-1:0]    stage0;
  logic [SW-1:0]    stage1;

  assign idx = cause[IDX_W-1:0];

  // fixed clear, forced set, then per-cause clear and set
  assign stage0    = (old_msr & ~ENTRY_CLEAR) | FORCE_SET;
  assign stage1    = stage0 & ~CAUSE_CLR[idx];
  assign new_msr   = stage1 | CAUSE_SET[idx];
  assign save_word = (old_msr & SAVE_KEEP & ~SAVE_CLR[idx]) | save_or;

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int            AW      = 32,
  parameter logic [AW-1:0] BASE_HI = 32'hFFF0_0000,
  parameter int            ILEN    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_cia,
  input  logic [SW-1:0]      req_msr,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [SUB_W-1:0]   req_sub,
  input  logic               req_store,
  input  logic [AW-1:0]      req_ea,
  output logic [AW-1:0]      srr0_o,
  output logic [SW-1:0]      srr1_o,
  output logic [SW-1:0]      msr_o,
  output logic [SW-1:0]      dsisr_o,
  output logic [AW-1:0]      dar_o,
  output logic [AW-1:0]      redirect_pc_o,
  output logic               redirect_vld_o,
  output logic               err_unrec_o,
  output logic               err_cause_o
);

  reason_t       rsn;
  logic [SW-1:0] nmsr;
  logic [SW-1:0] save_w;
  logic [AW-1:0] target;
  logic [AW-1:0] ret_addr;
  logic          take;
  logic          ok;

  exc_reason_dec u_dec (
    .cause    (req_cause),
    .sub      (req_sub),
    .is_store (req_store),
    .rsn      (rsn)
  );

  exc_state_calc u_state (
    .old_msr   (req_msr),
    .cause     (req_cause),
    .save_or   (rsn.save_or),
    .new_msr   (nmsr),
    .save_word (save_w)
  );

  exc_vector_sel #(.AW(AW), .BASE_HI(BASE_HI)) u_vec (
    .cause  (req_cause),
    .prefix (nmsr[B_IP]),
    .target (target)
  );

  assign take     = req_valid & req_ready;
  assign ok       = take & rsn.legal;
  assign ret_addr = (req_cause == C_SCALL) ? req_cia + AW'(ILEN) : req_cia;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready      <= 1'b0;
      srr0_o         <= '0;
      srr1_o         <= '0;
      msr_o          <= '0;
      dsisr_o        <= '0;
      dar_o          <= '0;
      redirect_pc_o  <= '0;
      redirect_vld_o <= 1'b0;
      err_unrec_o    <= 1'b0;
      err_cause_o    <= 1'b0;
    end else begin
      req_ready      <= 1'b1;
      redirect_vld_o <= ok;
      err_unrec_o    <= ok & ~req_msr[B_RI];
      err_cause_o    <= take & ~rsn.legal;
      if (ok) begin
        srr0_o        <= ret_addr;
        srr1_o        <= save_w;
        msr_o         <= nmsr;
        redirect_pc_o <= target;
        if (rsn.load_fault) begin
          dsisr_o <= rsn.fault_stat;
          dar_o   <= req_ea;
        end
      end
    end
  end

endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk
  import exc_entry_pkg::*;
#(
  parameter int AW = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [AW-1:0]      req_cia,
  input logic [CAUSE_W-1:0] req_cause,
  input logic [AW-1:0]      srr0_o,
  input logic [SW-1:0]      msr_o,
  input logic [SW-1:0]      dsisr_o,
  input logic [AW-1:0]      dar_o,
  input logic [AW-1:0]      redirect_pc_o,
  input logic               redirect_vld_o,
  input logic               err_unrec_o,
  input logic               err_cause_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    armed |-> req_ready);

  // R1, R11: every accepted request yields exactly one of strobe or cause error
  a_r1_strobe_follows_accept: assert property (@(posedge clk) disable iff (rst || !armed)
    (redirect_vld_o || err_cause_o) == $past(req_valid && req_ready));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(redirect_vld_o && err_cause_o));

  // R11: rejected request leaves the saved registers alone
  a_r11_bad_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    err_cause_o |-> ($stable(srr0_o) && $stable(msr_o) && $stable(dsisr_o)
                     && $stable(dar_o) && $stable(redirect_pc_o)));

  // R3
  a_r3_msr_cleared: assert property (@(posedge clk) disable iff (rst)
    redirect_vld_o |-> (msr_o[B_EE] == 1'b0 && msr_o[B_PR] == 1'b0 && msr_o[B_RI] == 1'b0));

  // R2
  a_r2_vector_aligned: assert property (@(posedge clk) disable iff (rst)
    redirect_vld_o |-> (redirect_pc_o[7:0] == 8'h00));

  // R5
  a_r5_scall_next: assert property (@(posedge clk) disable iff (rst || !armed)
    (redirect_vld_o && $past(req_cause) == C_SCALL) |-> (srr0_o == $past(req_cia) + AW'(4)));

  // R10
  a_r10_unrec_with_strobe: assert property (@(posedge clk) disable iff (rst)
    err_unrec_o |-> redirect_vld_o);

endmodule

bind exc_entry_unit exc_entry_unit_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_cia        (req_cia),
  .req_cause      (req_cause),
  .srr0_o         (srr0_o),
  .msr_o          (msr_o),
  .dsisr_o        (dsisr_o),
  .dar_o          (dar_o),
  .redirect_pc_o  (redirect_pc_o),
  .redirect_vld_o (redirect_vld_o),
  .err_unrec_o    (err_unrec_o),
  .err_cause_o    (err_cause_o)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_cia;
  logic [31:0] req_msr;
  logic [3:0]  req_cause;
  logic [2:0]  req_sub;
  logic        req_store;
  logic [31:0] req_ea;
  logic [31:0] srr0_o, srr1_o, msr_o, dsisr_o, dar_o, redirect_pc_o;
  logic        redirect_vld_o, err_unrec_o, err_cause_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cia(req_cia), .req_msr(req_msr), .req_cause(req_cause), .req_sub(req_sub),
    .req_store(req_store), .req_ea(req_ea), .srr0_o(srr0_o), .srr1_o(srr1_o),
    .msr_o(msr_o), .dsisr_o(dsisr_o), .dar_o(dar_o), .redirect_pc_o(redirect_pc_o),
    .redirect_vld_o(redirect_vld_o), .err_unrec_o(err_unrec_o), .err_cause_o(err_cause_o)
  );

  function automatic logic [31:0] x_msr(input logic [31:0] old);
    return old & ~32'h0004_EF32;
  endfunction

  function automatic logic [31:0] x_srr1(input logic [31:0] old, input logic [31:0] rsn);
    return (old & 32'h07C0_FFFF) | rsn;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive on falling edge, captured on the next rising edge, sampled on the following falling edge
  task automatic send(input logic [3:0] c, input logic [2:0] s, input logic st,
                      input logic [31:0] cia, input logic [31:0] m, input logic [31:0] ea);
    req_valid = 1'b1; req_cause = c; req_sub = s; req_store = st;
    req_cia = cia; req_msr = m; req_ea = ea;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 srr0", srr0_o, 0);
    chk("R12 srr1", srr1_o, 0);
    chk("R12 msr", msr_o, 0);
    chk("R12 dsisr", dsisr_o, 0);
    chk("R12 dar", dar_o, 0);
    chk("R12 pc", redirect_pc_o, 0);
    chk("R12 flags", {29'd0, redirect_vld_o, err_unrec_o, err_cause_o}, 0);
    chk("R1 ready", {31'd0, req_ready}, 1);
  endtask

  task automatic t_mchk();
    send(4'd0, 3'd0, 1'b0, 32'h0000_1000, 32'hFFFF_FFFF, 32'h0);
    chk("R1 strobe", {31'd0, redirect_vld_o}, 1);
    chk("R3 msr", msr_o, x_msr(32'hFFFF_FFFF));
    chk("R4 srr1", srr1_o, 32'h07C0_FFFF);
    chk("R5 srr0", srr0_o, 32'h0000_1000);
    chk("R2 prefixed base", redirect_pc_o, 32'hFFF0_0200);
    chk("R13 dsisr kept", dsisr_o, 0);
    chk("R10 no unrec", {31'd0, err_unrec_o}, 0);
    @(negedge clk);
    chk("R1 single pulse", {31'd0, redirect_vld_o}, 0);
  endtask

  task automatic t_dstor();
    send(4'd1, 3'd2, 1'b1, 32'h0000_2000, 32'h0000_0002, 32'hCAFE_0010);
    chk("R6 dsisr prot store", dsisr_o, 32'h0A00_0000);
    chk("R6 dar", dar_o, 32'hCAFE_0010);
    chk("R2 dstor vec", redirect_pc_o, 32'h0000_0300);
    chk("R3 msr", msr_o, 32'h0);
    send(4'd1, 3'd1, 1'b0, 32'h0000_2004, 32'h0000_8002, 32'h0000_0444);
    chk("R6 dsisr miss load", dsisr_o, 32'h4000_0000);
    send(4'd1, 3'd5, 1'b0, 32'h0000_2008, 32'h0000_0002, 32'h0000_0888);
    chk("R6 dsisr ext disabled", dsisr_o, 32'h0010_0000);
    send(4'd1, 3'd4, 1'b1, 32'h0000_200C, 32'h0000_0002, 32'h0000_0999);
    chk("R6 dsisr ext viol store", dsisr_o, 32'h0600_0000);
    chk("R6 dar 2", dar_o, 32'h0000_0999);
  endtask

  task automatic t_istor();
    send(4'd2, 3'd3, 1'b1, 32'h0000_3000, 32'hFFFF_FFFF, 32'h1234_5678);
    chk("R7 srr1 seg", srr1_o, x_srr1(32'hFFFF_FFFF, 32'h0020_0000));
    chk("R7 dsisr kept", dsisr_o, 32'h0600_0000);
    chk("R7 dar kept", dar_o, 32'h0000_0999);
    chk("R2 istor vec", redirect_pc_o, 32'hFFF0_0400);
    send(4'd2, 3'd1, 1'b0, 32'h0000_3004, 32'h0000_0002, 32'h0);
    chk("R7 srr1 direct", srr1_o, 32'h1000_0002);
  endtask

  task automatic t_align();
    send(4'd3, 3'd0, 1'b0, 32'h0000_4000, 32'h0000_0002, 32'h0000_0003);
    chk("R9 dsisr zero", dsisr_o, 0);
    chk("R9 dar", dar_o, 32'h0000_0003);
    chk("R2 align vec", redirect_pc_o, 32'h0000_0600);
  endtask

  task automatic t_prog();
    logic [31:0] exp [5] = '{32'h0010_0000, 32'h0008_0000, 32'h0004_0000,
                             32'h0002_0000, 32'h0008_0000};
    for (int i = 0; i < 5; i++) begin
      send(4'd4, 3'(i), 1'b0, 32'h0000_5000, 32'h0000_0002, 32'h0);
      chk("R8 program reason", srr1_o, 32'h0000_0002 | exp[i]);
    end
    chk("R2 prog vec", redirect_pc_o, 32'h0000_0700);
  endtask

  task automatic t_misc();
    send(4'd6, 3'd0, 1'b0, 32'h0000_6000, 32'h0000_4002, 32'h0);
    chk("R5 scall srr0", srr0_o, 32'h0000_6004);
    chk("R2 scall vec", redirect_pc_o, 32'h0000_0C00);
    chk("R13 scall srr1", srr1_o, 32'h0000_4002);
    send(4'd6, 3'd0, 1'b0, 32'hFFFF_FFFC, 32'h0000_0002, 32'h0);
    chk("R5 scall wrap", srr0_o, 32'h0);
    send(4'd5, 3'd0, 1'b0, 32'h0000_7000, 32'h0000_0002, 32'h0);
    chk("R2 fpun vec", redirect_pc_o, 32'h0000_0800);
    chk("R13 dar kept", dar_o, 32'h0000_0003);
    send(4'd7, 3'd0, 1'b0, 32'h0000_7004, 32'h0000_0042, 32'h0);
    chk("R2 fpas prefixed", redirect_pc_o, 32'hFFF0_0E00);
  endtask

  task automatic t_unrec();
    send(4'd0, 3'd0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'h0);
    chk("R10 unrec flag", {31'd0, err_unrec_o}, 1);
    chk("R10 strobe too", {31'd0, redirect_vld_o}, 1);
    chk("R10 srr0", srr0_o, 32'h0000_8000);
  endtask

  task automatic t_bad();
    send(4'd9, 3'd0, 1'b0, 32'h0000_9000, 32'h0000_0002, 32'h5555_5555);
    chk("R11 cause err", {31'd0, err_cause_o}, 1);
    chk("R11 no strobe", {31'd0, redirect_vld_o}, 0);
    chk("R11 srr0 kept", srr0_o, 32'h0000_8000);
    chk("R11 pc kept", redirect_pc_o, 32'h0000_0200);
    send(4'd1, 3'd7, 1'b1, 32'h0000_9004, 32'h0000_0002, 32'h6666_6666);
    chk("R11 bad sub err", {31'd0, err_cause_o}, 1);
    chk("R11 dar kept", dar_o, 32'h0000_0003);
    chk("R11 msr kept", msr_o, 32'h0000_8000 & ~32'h0004_EF32);
  endtask

  task automatic t_b2b();
    req_valid = 1'b1; req_cause = 4'd3; req_sub = 3'd0; req_store = 1'b0;
    req_cia = 32'h0000_A000; req_msr = 32'h0000_0002; req_ea = 32'h0000_0011;
    @(posedge clk); @(negedge clk);
    chk("R1 b2b first", {31'd0, redirect_vld_o}, 1);
    chk("R9 b2b dar", dar_o, 32'h0000_0011);
    req_cause = 4'd5; req_cia = 32'h0000_A004;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R1 b2b second", {31'd0, redirect_vld_o}, 1);
    chk("R1 b2b srr0", srr0_o, 32'h0000_A004);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_cause = '0; req_sub = '0; req_store = 1'b0;
    req_cia = '0; req_msr = '0; req_ea = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mchk();
    t_dstor();
    t_istor();
    t_align();
    t_prog();
    t_misc();
    t_unrec();
    t_bad();
    t_b2b();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule